// File: doc/BRIEF.md
# ECG QRS Band-Pass Filter Cascade

This block conditions a raw electrocardiogram sample stream ahead of a QRS detector. It chains two integer recursive filter stages with fixed coefficients. A low-pass section removes high-frequency noise. A high-pass section then removes baseline wander. Together they keep a pass band of roughly 5 Hz to 15 Hz, centred close to 10 Hz, which is where most of the QRS energy lies. The block uses no multipliers. Every coefficient is either a power of two, made with shifts, or a unit value, made with adders and subtractors.

Each stage holds a tapped history of its past inputs and registers of its own past outputs. A sample is taken whenever the input strobe is high. The filtered result appears on the output one clock later, together with a valid flag. The output holds its value between strobes. An asynchronous active-low reset sets all history and all outputs to zero, so the samples that follow a reset are filtered as if every earlier sample had been zero.

Top module: `qrs_bandpass`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, out_valid is 0 and out_sample is 0. All input and output history is zero, so the samples after any reset are filtered as if all earlier samples were zero.
- R2: out_valid is 1 in exactly those cycles that directly follow a cycle in which in_valid was high.
- R3: The low-pass stage computes lp[n] = 2·lp[n−1] − lp[n−2] + x[n] − 2·x[n−6] + x[n−12], where x is in_sample taken as signed two's complement.
- R4: The high-pass stage computes hp[n] = lp[n−16] − floor((hp[n−1] + lp[n] − lp[n−32]) / 32). The division is an arithmetic right shift by 5, which rounds toward negative infinity.
- R5: The two stages are cascaded. The lp value of the current sample feeds the high-pass stage in the same strobe cycle. out_sample equals hp[n].
- R6: In a cycle that does not follow a strobe, out_sample keeps its previous value.
- R7: History advances only on strobes. Idle cycles of any length between strobes leave the results unchanged.
- R8: Full-scale inputs of either polarity never overflow. The low-pass value stays within ±36·2^(IN_W−1), and out_sample matches the exact integer result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release must be synchronous to clk |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | High for one cycle after each strobe |
| out_sample | output | IN_W+9 | Signed filtered sample |

## Verification
The bench builds the block with the default 12-bit input width, so the internal width choices face full-scale values of +2047 and −2048. Long held steps at those values push the low-pass stage to its peak of 36 times the input, which tests the headroom claim. They also drive the high-pass feedback through negative sums, which tests the floor rounding of the shift. An impulse, strobes with gaps of several lengths, and a reset in the middle of a run test the tap positions, the rule that history advances only on strobes, and the clearing of history.

// File: rtl/qrs_bp_pkg.sv
package qrs_bp_pkg;
  // Tap positions and shift amounts are set by the fixed difference equations.
  localparam int LP_TAP_MID  = 6;
  localparam int LP_DEPTH    = 12;
  localparam int HP_TAP_MID  = 16;
  localparam int HP_DEPTH    = 32;
  localparam int HP_SHIFT    = 5;
  localparam int LP_DC_GAIN  = 36;
  // Extra bits on top of the input width for the low-pass accumulator
  localparam int LP_GROWTH   = 8;
endpackage

// File: rtl/qrs_tap_line.sv
module qrs_tap_line #(
  parameter int W     = 12,
  parameter int DEPTH = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic signed [W-1:0]             din,
  output logic        [DEPTH-1:0][W-1:0]  hist   // hist[k] holds the sample from k+1 strobes ago
);
  logic [DEPTH-1:0][W-1:0] hist_nxt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb hist_nxt[g] = din;
    end else begin : g_body
      always_comb hist_nxt[g] = hist[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (en) begin
      hist <= hist_nxt;
    end
  end
endmodule

// File: rtl/qrs_lowpass.sv
module qrs_lowpass
  import qrs_bp_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [ACC_W-1:0] y_nxt    // result for the current sample
);
  logic [LP_DEPTH-1:0][IN_W-1:0] hist;
  logic signed [ACC_W-1:0] y1_q, y2_q;
  logic signed [ACC_W-1:0] sx, sx_mid, sx_end;

  qrs_tap_line #(.W(IN_W), .DEPTH(LP_DEPTH)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .din  (x),
    .hist (hist)
  );

  always_comb begin
    sx     = ACC_W'(x);
    sx_mid = ACC_W'($signed(hist[LP_TAP_MID-1]));
    sx_end = ACC_W'($signed(hist[LP_DEPTH-1]));
    y_nxt  = (y1_q <<< 1) - y2_q + sx - (sx_mid <<< 1) + sx_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1_q <= '0;
      y2_q <= '0;
    end else if (en) begin
      y1_q <= y_nxt;
      y2_q <= y1_q;
    end
  end
endmodule

// File: rtl/qrs_highpass.sv
module qrs_highpass
  import qrs_bp_pkg::*;
#(
  parameter int IN_W  = 20,
  parameter int OUT_W = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y_q
);
  localparam int SUM_W = OUT_W + 2;

  logic [HP_DEPTH-1:0][IN_W-1:0] hist;
  logic signed [SUM_W-1:0] sum, scaled;
  logic signed [OUT_W-1:0] y_nxt;

  qrs_tap_line #(.W(IN_W), .DEPTH(HP_DEPTH)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .din  (x),
    .hist (hist)
  );

  always_comb begin
    sum    = SUM_W'(y_q) + SUM_W'(x) - SUM_W'($signed(hist[HP_DEPTH-1]));
    scaled = sum >>> HP_SHIFT;
    y_nxt  = OUT_W'(SUM_W'($signed(hist[HP_TAP_MID-1])) - scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= y_nxt;
    end
  end
endmodule

// File: rtl/qrs_bandpass.sv
module qrs_bandpass
  import qrs_bp_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [IN_W+LP_GROWTH:0] out_sample
);
  localparam int LP_W  = IN_W + LP_GROWTH;
  localparam int OUT_W = LP_W + 1;

  logic signed [LP_W-1:0] lp_y;
  logic                   valid_nxt;

  qrs_lowpass #(.IN_W(IN_W), .ACC_W(LP_W)) u_lp (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_valid),
    .x    (in_sample),
    .y_nxt(lp_y)
  );

  qrs_highpass #(.IN_W(LP_W), .OUT_W(OUT_W)) u_hp (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_valid),
    .x    (lp_y),
    .y_q  (out_sample)
  );

  always_comb valid_nxt = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end
endmodule

// File: rtl/qrs_bandpass_chk.sv
module qrs_bandpass_chk
  import qrs_bp_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int LP_W  = 20,
  parameter int OUT_W = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample,
  input logic signed [LP_W-1:0]  lp_y
);
  localparam int LP_BOUND = LP_DC_GAIN << (IN_W - 1);
  localparam int HP_BOUND = LP_BOUND + (LP_BOUND >>> 3);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                          // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                        // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));                               // R6
  AST_LP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(lp_y) <= LP_BOUND && int'(lp_y) >= -LP_BOUND)); // R8
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sample) <= HP_BOUND && int'(out_sample) >= -HP_BOUND)); // R8
endmodule

bind qrs_bandpass qrs_bandpass_chk #(
  .IN_W (IN_W),
  .LP_W (LP_W),
  .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .lp_y      (lp_y)
);

// File: tb/qrs_bandpass_tb.sv
module qrs_bandpass_tb;
  localparam int IN_W     = 12;
  localparam int OUT_W    = IN_W + 9;
  localparam int CLK_PER  = 10;
  localparam int FS_POS   = (1 << (IN_W - 1)) - 1;
  localparam int FS_NEG   = -(1 << (IN_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_sample = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  int expq[$];
  int last_out = 0;
  logic prev_strobe = 1'b0;
  bit done = 1'b0;

  // reference model state
  int lx[0:12];
  int hx[0:32];
  int ly1, ly2, hy1;

  always #(CLK_PER/2) clk = ~clk;

  qrs_bandpass #(.IN_W(IN_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  task automatic model_clear();
    for (int k = 0; k <= 12; k++) lx[k] = 0;
    for (int k = 0; k <= 32; k++) hx[k] = 0;
    ly1 = 0; ly2 = 0; hy1 = 0;
  endtask

  function automatic int model_step(input int x);
    int lp, hp;
    lp = 2*ly1 - ly2 + x - 2*lx[6] + lx[12];          // R3
    for (int k = 12; k >= 2; k--) lx[k] = lx[k-1];
    lx[1] = x;
    ly2 = ly1; ly1 = lp;
    hp = hx[16] - ((hy1 + lp - hx[32]) >>> 5);        // R4, R5
    for (int k = 32; k >= 2; k--) hx[k] = hx[k-1];
    hx[1] = lp;
    hy1 = hp;
    return hp;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: called just after a falling edge
  task automatic send(input int x, input int gap);
    in_valid  = 1'b1;
    in_sample = x[IN_W-1:0];
    expq.push_back(model_step(x));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  always @(posedge clk) prev_strobe <= rst_n && in_valid;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == prev_strobe, "R2 valid timing", int'(out_valid), int'(prev_strobe));
      if (out_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected output", int'(out_sample), 0);
        end else begin
          int e;
          e = expq.pop_front();
          check(int'(out_sample) == e, "R3/R4/R5/R8 sample", int'(out_sample), e);
        end
        last_out = int'(out_sample);
      end else begin
        check(int'(out_sample) == last_out, "R6 hold", int'(out_sample), last_out);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_clear();
    expq.delete();
    last_out = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(int'(out_sample) == 0, "R1 sample in reset", int'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(out_sample) == 0, "R1 sample after release", int'(out_sample), 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    model_clear();
    do_reset();
    // impulse, back-to-back strobes
    send(1, 0);
    for (int i = 0; i < 70; i++) send(0, 0);
    // positive full-scale step with idle gaps (R7, R8)
    for (int i = 0; i < 90; i++) send(FS_POS, i % 3);
    // negative full-scale step (R8, floor rounding R4)
    for (int i = 0; i < 90; i++) send(FS_NEG, (i % 5 == 0) ? 4 : 0);
    // reset mid-stream, then impulse again (R1 history clear)
    do_reset();
    send(-7, 1);
    for (int i = 0; i < 45; i++) send(0, 0);
    // pseudo-random samples with irregular gaps (R3, R4, R7)
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      int v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = int'($signed(lfsr[IN_W-1:0]));
      send(v, int'(lfsr[15:14]));
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2 all outputs seen", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule